// File: doc/BRIEF.md
# Pulse Program Sequencer with Loop Stack

This block is a small timing processor. It steps through a program of 80-bit instruction words held in an external memory. Each word carries four things: a 24-bit control pattern that the sequencer drives out, a 20-bit argument, a 4-bit operation code and a 32-bit hold count. The hold count sets how long the pattern stays on the outputs. Flow control covers plain advance, halt, counted repeat blocks, subroutine call and return, unconditional jump, a stretched hold that multiplies the hold count, and a pause that waits for a trigger. Two hardware stacks hold the repeat counters and the return addresses. Each stack nests up to eight levels.

Software or an external active-low trigger starts a run, but only while the armed input is high. An active-low halt input sends the sequencer back to address 0 and parks it there. Four one-hot status lines report halted, parked after reset, executing and pausing. A sticky error flag reports any push onto a full stack or pop from an empty one. The memory is read synchronously: the address shown on `mem_addr` in one cycle must return its word on `mem_rdata` in the next.

Top module: `pgm_seq`

## Requirements
- R1: After reset, `status` is 4'b0010, `ctrl_word` is 0, `mem_addr` is 0 and `stk_err` is 0.
- R2: A run starts only when `armed` is high and there is either a `sw_start` pulse or a falling edge on `hw_trig_n`, and only from the parked or halted state. The run begins at address 0, and the first pattern appears 3 cycles after the start is sampled. While `armed` is low, start and trigger have no effect.
- R3: Word fields are: pattern [79:56], argument [55:36], operation [35:32], hold count [31:0]. Operation 0 (advance) drives the pattern for hold+3 cycles and then moves to the next address.
- R4: Operation 1 (halt) leaves `ctrl_word` unchanged and sets `status` to 4'b0001.
- R5: Operation 2 (repeat) pushes its argument N as a count. Operation 3 (repeat end) jumps to the address in its argument until the block body has run N times, then falls through and pops. Blocks nest.
- R6: Operation 4 (call) jumps to its argument address and saves the following address. Operation 5 (return) resumes at the saved address.
- R7: Operation 6 (jump) continues at the address in its argument.
- R8: Operation 7 (stretch) holds its pattern for N*hold+3 cycles, where N is its argument (N >= 2), and then advances.
- R9: Operation 8 (pause) drives its pattern and sets `status` to 4'b1000 until an armed start or trigger arrives. The next pattern then appears hold+4 cycles after the cycle in which the trigger was driven.
- R10: While `hw_reset_n` is low, the next cycle shows `status` 4'b0010 and `mem_addr` 0 with `ctrl_word` held, and the sequencer stays parked until restarted.
- R11: A ninth nested push or a pop from an empty stack sets `stk_err`, halts without changing `ctrl_word`, and keeps `stk_err` set across later runs until `hw_reset_n` or `rst_n`.
- R12: `status` is always one-hot, and bit 2 is high while an instruction is fetched or held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| armed | input | 1 | Enables start and trigger |
| sw_start | input | 1 | Software start or resume pulse |
| hw_trig_n | input | 1 | Active-low trigger, acts on its falling edge |
| hw_reset_n | input | 1 | Active-low halt and return to address 0 |
| mem_rdata | input | 80 | Instruction word for the previous cycle's address |
| mem_addr | output | ADDR_W | Program memory address |
| ctrl_word | output | 24 | Output and control pattern |
| status | output | 4 | {pausing, executing, parked, halted} |
| stk_err | output | 1 | Sticky stack overflow or underflow flag |

## Verification
Pairs of hold counts from 6 to 9 are swept through two-instruction programs. Each per-instruction duration is measured, so a fixed-overhead error shows up apart from an error in the count itself. Repeat counts from 1 to 5 and a two-by-three nest tell an off-by-one in the loop exit apart from a bad jump target. Stretch factors 2 to 4 against two hold values separate a multiplied hold from an added one. Call chains and repeat chains nine deep land exactly one beyond the stack depth, and pauses released by either trigger source pin down the resume latency.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NEXT    = 4'd0,
    OP_HALT    = 4'd1,
    OP_RPT     = 4'd2,
    OP_RPT_END = 4'd3,
    OP_CALL    = 4'd4,
    OP_RET     = 4'd5,
    OP_JUMP    = 4'd6,
    OP_STRETCH = 4'd7,
    OP_PAUSE   = 4'd8
  } op_e;

  typedef enum logic [2:0] {
    S_RST    = 3'd0,
    S_FETCH  = 3'd1,
    S_DECODE = 3'd2,
    S_HOLD   = 3'd3,
    S_PAUSE  = 3'd4,
    S_HALT   = 3'd5
  } state_e;
endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/seq_trig.sv
module seq_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic sw_start,
  input  logic hw_trig_n,
  output logic go
);
  logic trig_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_prev_q <= 1'b1;
    else        trig_prev_q <= hw_trig_n;
  end

  // falling edge of the active-low trigger, or a software pulse
  assign go = armed & (sw_start | (trig_prev_q & ~hw_trig_n));
endmodule

// File: rtl/seq_lifo.sv
module seq_lifo #(
  parameter int W     = 20,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic         pop,
  input  logic         wr_top,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         full,
  output logic         empty
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  slot_q [DEPTH];
  logic [PW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] wr_idx, top_idx;
  logic          do_push, do_pop, do_wr;

  assign full    = (cnt_q == PW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push & ~full & ~clr;
  assign do_pop  = pop & ~empty & ~clr;
  assign do_wr   = wr_top & ~empty & ~clr;
  assign wr_idx  = IW'(cnt_q);
  assign top_idx = IW'(cnt_q - PW'(1));
  assign top     = slot_q[top_idx];

  always_comb begin
    cnt_d = cnt_q;
    if (clr)          cnt_d = '0;
    else if (do_push) cnt_d = cnt_q + PW'(1);
    else if (do_pop)  cnt_d = cnt_q - PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (do_push)    slot_q[wr_idx]  <= din;
    else if (do_wr) slot_q[top_idx] <= din;
  end
endmodule

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int DLY_W = 32,
  parameter int REP_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [DLY_W-1:0] dly_in,
  input  logic [REP_W-1:0] rep_in,
  output logic             expire
);
  logic [DLY_W-1:0] cnt_q, cnt_d, keep_q, keep_d;
  logic [REP_W-1:0] rep_q, rep_d;
  logic             cnt_zero, more_reps;

  assign cnt_zero  = (cnt_q == '0);
  assign more_reps = (rep_q > REP_W'(1));
  assign expire    = run & cnt_zero & ~more_reps;

  always_comb begin
    cnt_d  = cnt_q;
    rep_d  = rep_q;
    keep_d = keep_q;
    if (load) begin
      cnt_d  = dly_in;
      rep_d  = rep_in;
      keep_d = dly_in;
    end else if (run) begin
      if (!cnt_zero) begin
        cnt_d = cnt_q - DLY_W'(1);
      end else if (more_reps) begin
        // later passes add exactly keep cycles each
        cnt_d = keep_q - DLY_W'(1);
        rep_d = rep_q - REP_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rep_q  <= '0;
      keep_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      rep_q  <= rep_d;
      keep_q <= keep_d;
    end
  end
endmodule

// File: rtl/pgm_seq.sv
module pgm_seq
  import seq_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int STACK_DEPTH = 8,
  parameter int CTRL_W      = 24,
  parameter int ARG_W       = 20,
  parameter int DLY_W       = 32
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                armed,
  input  logic                                sw_start,
  input  logic                                hw_trig_n,
  input  logic                                hw_reset_n,
  input  logic [CTRL_W+ARG_W+OP_W+DLY_W-1:0]  mem_rdata,
  output logic [ADDR_W-1:0]                   mem_addr,
  output logic [CTRL_W-1:0]                   ctrl_word,
  output logic [3:0]                          status,
  output logic                                stk_err
);
  localparam int WORD_W  = CTRL_W + ARG_W + OP_W + DLY_W;
  localparam int OP_LSB  = DLY_W;
  localparam int ARG_LSB = DLY_W + OP_W;

  logic rst_n_s, go;

  seq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  seq_trig u_trig (
    .clk(clk), .rst_n(rst_n_s), .armed(armed), .sw_start(sw_start),
    .hw_trig_n(hw_trig_n), .go(go)
  );

  // instruction fields
  logic [CTRL_W-1:0] f_ctrl;
  logic [ARG_W-1:0]  f_arg;
  op_e               f_op;
  logic [DLY_W-1:0]  f_dly;
  logic [ADDR_W-1:0] arg_addr;

  assign f_ctrl   = mem_rdata[WORD_W-1 -: CTRL_W];
  assign f_arg    = mem_rdata[ARG_LSB +: ARG_W];
  assign f_op     = op_e'(mem_rdata[OP_LSB +: OP_W]);
  assign f_dly    = mem_rdata[DLY_W-1:0];
  assign arg_addr = ADDR_W'(f_arg);

  state_e            state_q, state_d;
  logic [ADDR_W-1:0] pc_q, pc_d, pc_inc;
  logic [CTRL_W-1:0] ctrl_q;
  logic              err_q, err_d;
  logic              ctrl_en, commit, fault;

  // stack and timer controls
  logic              stk_clr;
  logic              lp_push, lp_pop, lp_wr, lp_full, lp_empty;
  logic [ARG_W-1:0]  lp_din, lp_top;
  logic              cs_push, cs_pop, cs_full, cs_empty;
  logic [ADDR_W-1:0] cs_top;
  logic              tm_load, tm_run, tm_expire;
  logic [ARG_W-1:0]  tm_rep;

  assign pc_inc = pc_q + ADDR_W'(1);
  assign tm_run = (state_q == S_HOLD);

  seq_lifo #(.W(ARG_W), .DEPTH(STACK_DEPTH)) u_loop_stk (
    .clk(clk), .rst_n(rst_n_s), .clr(stk_clr), .push(lp_push), .pop(lp_pop),
    .wr_top(lp_wr), .din(lp_din), .top(lp_top), .full(lp_full), .empty(lp_empty)
  );

  seq_lifo #(.W(ADDR_W), .DEPTH(STACK_DEPTH)) u_call_stk (
    .clk(clk), .rst_n(rst_n_s), .clr(stk_clr), .push(cs_push), .pop(cs_pop),
    .wr_top(1'b0), .din(pc_inc), .top(cs_top), .full(cs_full), .empty(cs_empty)
  );

  seq_timer #(.DLY_W(DLY_W), .REP_W(ARG_W)) u_timer (
    .clk(clk), .rst_n(rst_n_s), .load(tm_load), .run(tm_run),
    .dly_in(f_dly), .rep_in(tm_rep), .expire(tm_expire)
  );

  always_comb begin
    state_d = state_q;
    pc_d    = pc_q;
    err_d   = err_q;
    stk_clr = 1'b0;
    lp_push = 1'b0;
    lp_pop  = 1'b0;
    lp_wr   = 1'b0;
    lp_din  = f_arg;
    cs_push = 1'b0;
    cs_pop  = 1'b0;
    tm_load = 1'b0;
    tm_rep  = ARG_W'(1);
    commit  = 1'b0;
    fault   = 1'b0;
    if (!hw_reset_n) begin
      state_d = S_RST;
      pc_d    = '0;
      stk_clr = 1'b1;
      err_d   = 1'b0;
    end else begin
      case (state_q)
        S_RST, S_HALT: begin
          if (go) begin
            state_d = S_FETCH;
            pc_d    = '0;
            stk_clr = 1'b1;
          end
        end
        S_FETCH: state_d = S_DECODE;
        S_HOLD:  if (tm_expire) state_d = S_FETCH;
        S_PAUSE: if (go) state_d = S_HOLD;
        S_DECODE: begin
          pc_d   = pc_inc;
          commit = 1'b1;
          case (f_op)
            OP_HALT: begin
              commit  = 1'b0;
              state_d = S_HALT;
            end
            OP_RPT: begin
              if (lp_full) fault = 1'b1;
              else         lp_push = 1'b1;
            end
            OP_RPT_END: begin
              if (lp_empty) begin
                fault = 1'b1;
              end else if (lp_top > ARG_W'(1)) begin
                lp_wr  = 1'b1;
                lp_din = lp_top - ARG_W'(1);
                pc_d   = arg_addr;
              end else begin
                lp_pop = 1'b1;
              end
            end
            OP_CALL: begin
              if (cs_full) begin
                fault = 1'b1;
              end else begin
                cs_push = 1'b1;
                pc_d    = arg_addr;
              end
            end
            OP_RET: begin
              if (cs_empty) begin
                fault = 1'b1;
              end else begin
                cs_pop = 1'b1;
                pc_d   = cs_top;
              end
            end
            OP_JUMP:    pc_d   = arg_addr;
            OP_STRETCH: tm_rep = f_arg;
            default: ;
          endcase
          if (fault) begin
            commit  = 1'b0;
            err_d   = 1'b1;
            state_d = S_HALT;
            pc_d    = pc_q;
          end
          if (commit) begin
            tm_load = 1'b1;
            state_d = (f_op == OP_PAUSE) ? S_PAUSE : S_HOLD;
          end
        end
        default: state_d = S_RST;
      endcase
    end
  end

  assign ctrl_en = commit & hw_reset_n;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= S_RST;
      pc_q    <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= f_ctrl;
  end

  assign mem_addr  = pc_q;
  assign ctrl_word = ctrl_q;
  assign stk_err   = err_q;
  assign status    = {state_q == S_PAUSE,
                      (state_q == S_FETCH) || (state_q == S_DECODE) || (state_q == S_HOLD),
                      state_q == S_RST,
                      state_q == S_HALT};
endmodule

// File: rtl/seq_chk.sv
module seq_chk #(
  parameter int ADDR_W = 15,
  parameter int CTRL_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              armed,
  input logic              hw_reset_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [CTRL_W-1:0] ctrl_word,
  input logic [3:0]        status,
  input logic              stk_err
);
  // R12
  status_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(status) == 1);

  // R2
  unarmed_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 4'b0010 && !armed) |=> status == 4'b0010);

  // R4
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] |=> $stable(ctrl_word));

  // R9
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[3] |=> $stable(ctrl_word));

  // R10
  hw_reset_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_reset_n |=> (status == 4'b0010 && mem_addr == '0));

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_err && hw_reset_n) |=> stk_err);

  // R11
  err_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stk_err) |-> status[0]);
endmodule

bind pgm_seq seq_chk #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .armed(armed), .hw_reset_n(hw_reset_n),
  .mem_addr(mem_addr), .ctrl_word(ctrl_word), .status(status), .stk_err(stk_err)
);

// File: tb/sim_pgm_seq.sv
module sim_pgm_seq;
  localparam int AW = 6;
  localparam int C_NEXT = 0, C_HALT = 1, C_RPT = 2, C_RPTE = 3, C_CALL = 4,
                 C_RET = 5, C_JUMP = 6, C_STR = 7, C_PAUSE = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, armed, sw_start, hw_trig_n, hw_reset_n;
  logic [79:0]   mem_rdata;
  logic [AW-1:0] mem_addr;
  logic [23:0]   ctrl_word;
  logic [3:0]    status;
  logic          stk_err;

  pgm_seq #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .armed(armed), .sw_start(sw_start),
    .hw_trig_n(hw_trig_n), .hw_reset_n(hw_reset_n), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .ctrl_word(ctrl_word), .status(status), .stk_err(stk_err)
  );

  logic [79:0] prog [64];
  always @(posedge clk) mem_rdata <= prog[mem_addr];

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // pattern change monitor
  int          n_ev = 0;
  logic [23:0] ev_val [256];
  int          ev_t [256];
  logic [23:0] last_seen = '0;
  always @(negedge clk) begin
    if (ctrl_word !== last_seen) begin
      if (n_ev < 256) begin
        ev_val[n_ev] = ctrl_word;
        ev_t[n_ev]   = cyc;
      end
      n_ev++;
      last_seen = ctrl_word;
    end
  end

  int n_chk = 0, n_fail = 0;
  int rid = 0, base = 0, c_start = 0, t_end = 0, c_trig = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [79:0] w(input int c, input int a, input int op, input int d);
    return {rid[7:0], c[15:0], a[19:0], op[3:0], d[31:0]};
  endfunction

  function automatic longint cv(input int c);
    return longint'({rid[7:0], c[15:0]});
  endfunction

  task automatic new_prog();
    rid++;
    for (int i = 0; i < 64; i++) prog[i] = w(100 + i, 0, C_HALT, 6);
  endtask

  task automatic kick();
    @(negedge clk);
    base = n_ev; c_start = cyc; armed = 1'b1; sw_start = 1'b1;
    @(negedge clk);
    sw_start = 1'b0;
  endtask

  task automatic wait_halt(input string req);
    int k = 0;
    while (!status[0] && k < 5000) begin
      @(negedge clk);
      k++;
    end
    t_end = cyc;
    chk(req, "run reaches halt", k < 5000, 1);
  endtask

  task automatic pulse_trig();
    @(negedge clk);
    c_trig = cyc; hw_trig_n = 1'b0;
    @(negedge clk);
    hw_trig_n = 1'b1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual expired expected finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; armed = 1'b0; sw_start = 1'b0; hw_trig_n = 1'b1; hw_reset_n = 1'b1;
    new_prog();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1", "status", status, 4'b0010);
    chk("R1", "ctrl_word", ctrl_word, 0);
    chk("R1", "mem_addr", mem_addr, 0);
    chk("R1", "stk_err", stk_err, 0);

    // R2 unarmed start and trigger ignored
    prog[0] = w(1, 0, C_NEXT, 6);
    base = n_ev;
    @(negedge clk); sw_start = 1'b1;
    @(negedge clk); sw_start = 1'b0;
    pulse_trig();
    repeat (12) @(negedge clk);
    chk("R2", "unarmed status", status, 4'b0010);
    chk("R2", "unarmed no pattern", n_ev - base, 0);

    // R3 hold sweep, R4 halt, R2 start latency, R12 executing
    for (int d1 = 6; d1 <= 9; d1++) begin
      for (int d2 = 6; d2 <= 8; d2++) begin
        new_prog();
        prog[0] = w(1, 0, C_NEXT, d1);
        prog[1] = w(2, 0, C_NEXT, d2);
        prog[2] = w(3, 0, C_HALT, 6);
        kick();
        chk("R12", "executing status", status, 4'b0100);
        wait_halt("R3");
        chk("R3", "pattern count", n_ev - base, 2);
        chk("R3", "first pattern", ev_val[base], cv(1));
        chk("R2", "start latency", ev_t[base] - c_start, 3);
        chk("R3", "first duration", ev_t[base+1] - ev_t[base], d1 + 3);
        chk("R3", "second duration", t_end - ev_t[base+1], d2 + 3);
        chk("R4", "halt keeps pattern", ctrl_word, cv(2));
        chk("R4", "halt status", status, 4'b0001);
      end
    end

    // R5 repeat counts 1..5
    for (int n = 1; n <= 5; n++) begin
      new_prog();
      prog[0] = w(1, n, C_RPT, 6);
      prog[1] = w(2, 0, C_NEXT, 7);
      prog[2] = w(3, 1, C_RPTE, 6);
      prog[3] = w(4, 0, C_HALT, 6);
      kick();
      wait_halt("R5");
      chk("R5", "pattern count", n_ev - base, 1 + 2 * n);
      chk("R5", "last pattern", ev_val[base + 2 * n], cv(3));
      chk("R5", "total cycles", t_end - ev_t[base], 9 + n * 19);
    end

    // R5 nested 2 x 3
    new_prog();
    prog[0] = w(1, 2, C_RPT, 6);
    prog[1] = w(2, 3, C_RPT, 6);
    prog[2] = w(3, 0, C_NEXT, 6);
    prog[3] = w(4, 2, C_RPTE, 6);
    prog[4] = w(5, 1, C_RPTE, 6);
    kick();
    wait_halt("R5");
    chk("R5", "nested pattern count", n_ev - base, 17);
    chk("R5", "nested total cycles", t_end - ev_t[base], 17 * 9);

    // R6 call and return
    new_prog();
    prog[0] = w(1, 4, C_CALL, 6);
    prog[1] = w(2, 0, C_NEXT, 6);
    prog[4] = w(7, 0, C_NEXT, 6);
    prog[5] = w(8, 0, C_RET, 6);
    kick();
    wait_halt("R6");
    chk("R6", "pattern count", n_ev - base, 4);
    chk("R6", "subroutine entry", ev_val[base+1], cv(7));
    chk("R6", "return point", ev_val[base+3], cv(2));

    // R7 jump
    new_prog();
    prog[0] = w(1, 3, C_JUMP, 6);
    prog[1] = w(9, 0, C_NEXT, 6);
    prog[3] = w(4, 0, C_NEXT, 6);
    kick();
    wait_halt("R7");
    chk("R7", "pattern count", n_ev - base, 2);
    chk("R7", "jump target", ev_val[base+1], cv(4));

    // R8 stretch sweep
    for (int n = 2; n <= 4; n++) begin
      for (int d = 6; d <= 7; d++) begin
        new_prog();
        prog[0] = w(1, n, C_STR, d);
        prog[1] = w(2, 0, C_NEXT, 6);
        kick();
        wait_halt("R8");
        chk("R8", "stretched duration", ev_t[base+1] - ev_t[base], n * d + 3);
      end
    end

    // R9 pause, released by software then by trigger
    for (int i = 0; i < 2; i++) begin
      int k = 0;
      int d = (i == 0) ? 6 : 10;
      new_prog();
      prog[0] = w(1, 0, C_NEXT, 6);
      prog[1] = w(2, 0, C_PAUSE, d);
      prog[2] = w(3, 0, C_NEXT, 6);
      kick();
      while (!status[3] && k < 200) begin @(negedge clk); k++; end
      repeat (20) @(negedge clk);
      chk("R9", "pausing status", status, 4'b1000);
      chk("R9", "pause pattern", ctrl_word, cv(2));
      armed = 1'b0;
      pulse_trig();
      repeat (5) @(negedge clk);
      chk("R9", "unarmed trigger ignored in pause", status, 4'b1000);
      armed = 1'b1;
      if (i == 0) begin
        @(negedge clk);
        c_trig = cyc; sw_start = 1'b1;
        @(negedge clk);
        sw_start = 1'b0;
      end else begin
        pulse_trig();
      end
      wait_halt("R9");
      chk("R9", "resume latency", ev_t[base+2] - c_trig, d + 4);
    end

    // R10 hardware halt mid-run, then restart by trigger
    new_prog();
    prog[0] = w(1, 0, C_NEXT, 200);
    kick();
    repeat (20) @(negedge clk);
    hw_reset_n = 1'b0;
    @(negedge clk);
    chk("R10", "parked status", status, 4'b0010);
    chk("R10", "address zero", mem_addr, 0);
    chk("R10", "pattern held", ctrl_word, cv(1));
    hw_reset_n = 1'b1;
    repeat (250) @(negedge clk);
    chk("R10", "still parked", status, 4'b0010);
    chk("R10", "pattern still held", ctrl_word, cv(1));
    prog[0] = w(5, 0, C_NEXT, 6);
    base = n_ev;
    pulse_trig();
    wait_halt("R10");
    chk("R10", "restart from zero", ev_val[base], cv(5));
    chk("R2", "trigger start latency", ev_t[base] - c_trig, 3);

    // R11 call overflow at ninth level
    new_prog();
    for (int i = 0; i < 9; i++) prog[i] = w(i + 1, i + 1, C_CALL, 6);
    kick();
    wait_halt("R11");
    chk("R11", "call overflow patterns", n_ev - base, 8);
    chk("R11", "call overflow flag", stk_err, 1);
    chk("R11", "pattern unchanged", ctrl_word, cv(8));
    chk("R11", "halted", status, 4'b0001);

    // R11 repeat overflow and stickiness
    new_prog();
    for (int i = 0; i < 9; i++) prog[i] = w(i + 1, 2, C_RPT, 6);
    kick();
    wait_halt("R11");
    chk("R11", "repeat overflow patterns", n_ev - base, 8);
    chk("R11", "repeat overflow flag", stk_err, 1);
    new_prog();
    prog[0] = w(1, 0, C_NEXT, 6);
    kick();
    wait_halt("R11");
    chk("R11", "flag sticky over clean run", stk_err, 1);
    @(negedge clk); hw_reset_n = 1'b0;
    @(negedge clk); hw_reset_n = 1'b1;
    @(negedge clk);
    chk("R11", "flag cleared by hw reset", stk_err, 0);

    // R11 underflow on return and on repeat end
    new_prog();
    prog[0] = w(1, 0, C_RET, 6);
    kick();
    wait_halt("R11");
    chk("R11", "return underflow flag", stk_err, 1);
    chk("R11", "return underflow no pattern", n_ev - base, 0);
    @(negedge clk); hw_reset_n = 1'b0;
    @(negedge clk); hw_reset_n = 1'b1;
    new_prog();
    prog[0] = w(1, 0, C_RPTE, 6);
    kick();
    wait_halt("R11");
    chk("R11", "repeat end underflow flag", stk_err, 1);

    summary();
    $finish;
  end
endmodule